// File: doc/BRIEF.md
# Thread Block Grid Distributor

The distributor accepts one grid launch at a time, made of a count of thread blocks and a uniform per-multiprocessor slot count (the result of an earlier admission step), and hands the blocks out one at a time to a fixed set of multiprocessors. Every block goes to exactly one multiprocessor. Blocks are spread as widely as possible: a multiprocessor gets a second block only when every multiprocessor that still has room already holds one.

When every slot is taken, the distributor stops offering blocks. It resumes only when a multiprocessor reports that one of its blocks has finished. The result is a series of waves. The block counts the waves it has started and reports how many multiprocessors the final wave leaves without work. A done flag marks the point where the whole grid has been dispatched and has retired. Block execution is represented only by the per-multiprocessor completion handshakes.

Top module: `grid_distributor`

## Requirements
- R1: `launch_ready` is high exactly when no grid is in progress. Taking a launch latches the block count and the slot count and clears `done`, except in the zero case of R8. Reset leaves `done` low.
- R2: Block ids 0 to N-1 are offered once each, in ascending order, and each is handed to exactly one multiprocessor. While `asg_valid` is high and `asg_ready` is low, `asg_block` and `asg_sm` hold their values.
- R3: No multiprocessor ever holds more outstanding blocks than the slot count. The total outstanding never exceeds the slot count times the multiprocessor count.
- R4: An offer targets a non-full multiprocessor with the fewest outstanding blocks. Ties go round-robin, starting from the index after the last multiprocessor that was assigned. After reset the last index is the highest one, so the first block goes to multiprocessor 0. With fewer blocks than multiprocessors, only that many receive work.
- R5: `cpl_ready[i]` is high exactly when multiprocessor i has at least one outstanding block. An accepted completion frees one of its slots. An assignment and a completion on the same multiprocessor in one cycle leave its count unchanged.
- R6: When all slots are full, `asg_valid` stays low. It rises in the cycle after a completion is accepted.
- R7: `done` rises in the cycle after the completion handshake of the last outstanding block, once all N blocks have been assigned. It stays high until the next launch is taken.
- R8: A launch with zero blocks or zero slots raises `done` in the cycle after it is taken. It makes no offer, and it leaves `wave_count` at 0 and `tail_idle` equal to the multiprocessor count.
- R9: `wave_count` equals the ceiling of blocks assigned so far divided by the capacity. After the whole grid it is ceil(N / capacity); for example, 20 blocks on 16 slots give 2.
- R10: `tail_idle` equals the multiprocessor count minus min(r, multiprocessor count), where r = assigned − (wave_count − 1) × capacity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_valid | input | 1 | Grid launch request |
| launch_ready | output | 1 | Distributor is free to take a launch |
| launch_blocks | input | BLK_W | Number of blocks in the grid |
| launch_slots | input | SLOT_W | Block slots per multiprocessor |
| asg_valid | output | 1 | An assignment is offered |
| asg_ready | input | 1 | Assignment accepted |
| asg_block | output | BLK_W | Block id being assigned |
| asg_sm | output | SM_W | Target multiprocessor |
| cpl_valid | input | NUM_SM | Per-multiprocessor completion request |
| cpl_ready | output | NUM_SM | Per-multiprocessor completion accept |
| done | output | 1 | Grid fully dispatched and retired |
| wave_count | output | BLK_W | Waves started so far |
| tail_idle | output | SM_W+1 | Multiprocessors left idle in the latest wave |

## Verification
Two events can coincide in one cycle: an assignment to a multiprocessor and a completion from that same multiprocessor. The bench stalls a full grid and frees a slot on one multiprocessor. It holds `asg_ready` low while other multiprocessors complete, to confirm the held offer, and then accepts the offer in the same cycle that the target multiprocessor retires a block. A cycle-level model built from the requirements judges the result. It expects that multiprocessor's count to stay at one, and it checks every later target choice and every `cpl_ready` bit against that expectation.

// File: rtl/grid_dist_pkg.sv
package grid_dist_pkg;

   typedef enum logic {
      GD_IDLE = 1'b0,
      GD_RUN  = 1'b1
   } gd_state_e;

endpackage

// File: rtl/gd_slot_bank.sv
module gd_slot_bank #(
   parameter int NUM_SM = 8,
   parameter int SLOT_W = 4,
   parameter int SM_W   = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           add_en,
   input  logic [SM_W-1:0]                add_sm,
   input  logic [NUM_SM-1:0]              rel,
   output logic [NUM_SM-1:0][SLOT_W-1:0]  occ,
   output logic [NUM_SM-1:0]              busy
);

   localparam logic [SLOT_W-1:0] ONE = SLOT_W'(1);

   for (genvar g = 0; g < NUM_SM; g++) begin : g_sm
      logic hit;
      assign hit     = add_en && (add_sm == SM_W'(g));
      assign busy[g] = (occ[g] != '0);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            occ[g] <= '0;
         end else if (hit && !rel[g]) begin
            occ[g] <= occ[g] + ONE;
         end else if (!hit && rel[g]) begin
            occ[g] <= occ[g] - ONE;
         end
      end
   end

endmodule

// File: rtl/gd_pick.sv
module gd_pick #(
   parameter int NUM_SM = 8,
   parameter int SLOT_W = 4,
   parameter int SM_W   = 3
) (
   input  logic [NUM_SM-1:0][SLOT_W-1:0] occ,
   input  logic [SLOT_W-1:0]             slots,
   input  logic [SM_W-1:0]               last,
   output logic [SM_W-1:0]               pick_sm,
   output logic                          pick_ok
);

   logic [SLOT_W-1:0] min_v;
   logic              any_room;
   logic [NUM_SM-1:0] cand;

   // lowest load among multiprocessors that still have room
   always_comb begin
      min_v    = '1;
      any_room = 1'b0;
      for (int i = 0; i < NUM_SM; i++) begin
         if (occ[i] < slots) begin
            if (!any_room || (occ[i] < min_v)) begin
               min_v = occ[i];
            end
            any_room = 1'b1;
         end
      end
   end

   always_comb begin
      for (int i = 0; i < NUM_SM; i++) begin
         cand[i] = (occ[i] < slots) && (occ[i] == min_v);
      end
   end

   // rotating scan beginning just past the last target
   always_comb begin
      pick_sm = '0;
      pick_ok = 1'b0;
      for (int k = 1; k <= NUM_SM; k++) begin
         if (!pick_ok && cand[(int'(last) + k) % NUM_SM]) begin
            pick_sm = SM_W'((int'(last) + k) % NUM_SM);
            pick_ok = 1'b1;
         end
      end
   end

endmodule

// File: rtl/gd_wave_meter.sv
module gd_wave_meter #(
   parameter int NUM_SM = 8,
   parameter int BLK_W  = 16,
   parameter int CAP_W  = 8,
   parameter int SM_W   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic [CAP_W-1:0] cap,
   input  logic             step,
   output logic [BLK_W-1:0] waves,
   output logic [SM_W:0]    tail_idle
);

   localparam logic [CAP_W-1:0] SM_CNT = CAP_W'(NUM_SM);

   logic [CAP_W-1:0] in_wave;
   logic [CAP_W-1:0] in_wave_inc;
   logic [CAP_W-1:0] rem;

   assign in_wave_inc = in_wave + CAP_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         in_wave <= '0;
         waves   <= '0;
      end else if (step) begin
         if (in_wave == '0) begin
            waves <= waves + BLK_W'(1);
         end
         in_wave <= (in_wave_inc == cap) ? '0 : in_wave_inc;
      end
   end

   always_comb begin
      rem = (in_wave == '0) ? cap : in_wave;
      if (waves == '0) begin
         tail_idle = (SM_W+1)'(NUM_SM);
      end else if (rem >= SM_CNT) begin
         tail_idle = '0;
      end else begin
         tail_idle = (SM_W+1)'(SM_CNT - rem);
      end
   end

endmodule

// File: rtl/grid_distributor.sv
module grid_distributor #(
   parameter int NUM_SM = 8,
   parameter int SLOT_W = 4,
   parameter int BLK_W  = 16,
   localparam int SM_W  = $clog2(NUM_SM)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 launch_valid,
   output logic                 launch_ready,
   input  logic [BLK_W-1:0]     launch_blocks,
   input  logic [SLOT_W-1:0]    launch_slots,
   output logic                 asg_valid,
   input  logic                 asg_ready,
   output logic [BLK_W-1:0]     asg_block,
   output logic [SM_W-1:0]      asg_sm,
   input  logic [NUM_SM-1:0]    cpl_valid,
   output logic [NUM_SM-1:0]    cpl_ready,
   output logic                 done,
   output logic [BLK_W-1:0]     wave_count,
   output logic [SM_W:0]        tail_idle
);
   import grid_dist_pkg::*;

   localparam int CAP_W = SLOT_W + SM_W + 1;

   if (NUM_SM < 2) begin : g_bad_sm
      $error("grid_distributor: NUM_SM must be at least 2");
   end
   if (SLOT_W < 1) begin : g_bad_slot
      $error("grid_distributor: SLOT_W must be at least 1");
   end
   if (BLK_W < 2) begin : g_bad_blk
      $error("grid_distributor: BLK_W must be at least 2");
   end

   gd_state_e                   state;
   logic [BLK_W-1:0]            n_blocks;
   logic [SLOT_W-1:0]           slots_r;
   logic [CAP_W-1:0]            cap_r;
   logic [BLK_W-1:0]            issued;
   logic [BLK_W-1:0]            issued_next;
   logic [BLK_W-1:0]            outstanding;
   logic [BLK_W-1:0]            out_next;
   logic [SM_W-1:0]             last_sm;
   logic                        held;
   logic [SM_W-1:0]             held_sm;
   logic [NUM_SM-1:0][SLOT_W-1:0] occ;
   logic [NUM_SM-1:0]           busy;
   logic [NUM_SM-1:0]           cpl_fire;
   logic [SM_W:0]               n_rel;
   logic [SM_W-1:0]             pick_sm;
   logic                        pick_ok;
   logic                        fire_asg;
   logic                        launch_acc;
   logic                        empty_grid;

   assign launch_ready = (state == GD_IDLE);
   assign launch_acc   = launch_valid && launch_ready;
   assign empty_grid   = (launch_blocks == '0) || (launch_slots == '0);

   assign cpl_ready = busy;
   assign cpl_fire  = cpl_valid & busy;

   assign asg_valid = (state == GD_RUN) && (issued != n_blocks) && (held || pick_ok);
   assign asg_sm    = held ? held_sm : pick_sm;
   assign asg_block = issued;
   assign fire_asg  = asg_valid && asg_ready;

   always_comb begin
      n_rel = '0;
      for (int i = 0; i < NUM_SM; i++) begin
         n_rel = n_rel + (SM_W+1)'(cpl_fire[i]);
      end
   end

   assign issued_next = issued + BLK_W'(fire_asg);
   assign out_next    = outstanding + BLK_W'(fire_asg) - BLK_W'(n_rel);

   gd_slot_bank #(
      .NUM_SM (NUM_SM),
      .SLOT_W (SLOT_W),
      .SM_W   (SM_W)
   ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .add_en (fire_asg),
      .add_sm (asg_sm),
      .rel    (cpl_fire),
      .occ    (occ),
      .busy   (busy)
   );

   gd_pick #(
      .NUM_SM (NUM_SM),
      .SLOT_W (SLOT_W),
      .SM_W   (SM_W)
   ) u_pick (
      .occ     (occ),
      .slots   (slots_r),
      .last    (last_sm),
      .pick_sm (pick_sm),
      .pick_ok (pick_ok)
   );

   gd_wave_meter #(
      .NUM_SM (NUM_SM),
      .BLK_W  (BLK_W),
      .CAP_W  (CAP_W),
      .SM_W   (SM_W)
   ) u_waves (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (launch_acc),
      .cap       (cap_r),
      .step      (fire_asg),
      .waves     (wave_count),
      .tail_idle (tail_idle)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= GD_IDLE;
         n_blocks    <= '0;
         slots_r     <= '0;
         cap_r       <= '0;
         issued      <= '0;
         outstanding <= '0;
         last_sm     <= SM_W'(NUM_SM - 1);
         held        <= 1'b0;
         held_sm     <= '0;
         done        <= 1'b0;
      end else begin
         outstanding <= out_next;
         if (launch_acc) begin
            n_blocks <= launch_blocks;
            slots_r  <= launch_slots;
            cap_r    <= CAP_W'(launch_slots) * CAP_W'(NUM_SM);
            issued   <= '0;
            held     <= 1'b0;
            done     <= empty_grid;
            state    <= empty_grid ? GD_IDLE : GD_RUN;
         end else begin
            issued  <= issued_next;
            held    <= asg_valid && !asg_ready;
            held_sm <= asg_sm;
            if (fire_asg) begin
               last_sm <= asg_sm;
            end
            if ((state == GD_RUN) && (issued_next == n_blocks) && (out_next == '0)) begin
               done  <= 1'b1;
               state <= GD_IDLE;
            end
         end
      end
   end

endmodule

// File: rtl/grid_distributor_chk.sv
module grid_distributor_chk #(
   parameter int NUM_SM = 8,
   parameter int SLOT_W = 4,
   parameter int BLK_W  = 16,
   localparam int SM_W  = $clog2(NUM_SM),
   localparam int CAP_W = SLOT_W + SM_W + 1
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           launch_ready,
   input logic                           asg_valid,
   input logic                           asg_ready,
   input logic [BLK_W-1:0]               asg_block,
   input logic [SM_W-1:0]                asg_sm,
   input logic [NUM_SM-1:0]              cpl_valid,
   input logic [NUM_SM-1:0]              cpl_ready,
   input logic                           done,
   input logic [NUM_SM-1:0][SLOT_W-1:0]  occ,
   input logic [SLOT_W-1:0]              slots_r,
   input logic [BLK_W-1:0]               outstanding,
   input logic [CAP_W-1:0]               cap_r
);

   localparam logic [SLOT_W-1:0] ONE = SLOT_W'(1);

   assert_payload_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (asg_valid && !asg_ready) |=> (asg_valid && $stable(asg_sm) && $stable(asg_block)));

   assert_cap_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      asg_valid |-> (CAP_W'(outstanding) < cap_r));

   assert_target_room_R4: assert property (@(posedge clk) disable iff (!rst_n)
      asg_valid |-> (occ[asg_sm] < slots_r));

   assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!asg_valid && (outstanding == '0)));

   assert_launch_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
      launch_ready |-> (outstanding == '0));

   for (genvar g = 0; g < NUM_SM; g++) begin : g_per_sm
      assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
         occ[g] <= slots_r);

      assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (cpl_valid[g] && cpl_ready[g] && !(asg_valid && asg_ready && (asg_sm == SM_W'(g))))
         |=> (occ[g] == $past(occ[g]) - ONE));
   end

endmodule

bind grid_distributor grid_distributor_chk #(
   .NUM_SM (NUM_SM),
   .SLOT_W (SLOT_W),
   .BLK_W  (BLK_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .launch_ready (launch_ready),
   .asg_valid    (asg_valid),
   .asg_ready    (asg_ready),
   .asg_block    (asg_block),
   .asg_sm       (asg_sm),
   .cpl_valid    (cpl_valid),
   .cpl_ready    (cpl_ready),
   .done         (done),
   .occ          (occ),
   .slots_r      (slots_r),
   .outstanding  (outstanding),
   .cap_r        (cap_r)
);

// File: tb/grid_distributor_tb.sv
module grid_distributor_tb;

   localparam int S      = 8;
   localparam int SLOT_W = 4;
   localparam int BLK_W  = 16;
   localparam int SM_W   = $clog2(S);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              launch_valid = 1'b0;
   logic              launch_ready;
   logic [BLK_W-1:0]  launch_blocks = '0;
   logic [SLOT_W-1:0] launch_slots = '0;
   logic              asg_valid;
   logic              asg_ready = 1'b0;
   logic [BLK_W-1:0]  asg_block;
   logic [SM_W-1:0]   asg_sm;
   logic [S-1:0]      cpl_valid = '0;
   logic [S-1:0]      cpl_ready;
   logic              done;
   logic [BLK_W-1:0]  wave_count;
   logic [SM_W:0]     tail_idle;

   always #4 clk = ~clk;   // 125 MHz

   grid_distributor #(.NUM_SM(S), .SLOT_W(SLOT_W), .BLK_W(BLK_W)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .launch_valid(launch_valid), .launch_ready(launch_ready),
      .launch_blocks(launch_blocks), .launch_slots(launch_slots),
      .asg_valid(asg_valid), .asg_ready(asg_ready),
      .asg_block(asg_block), .asg_sm(asg_sm),
      .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
      .done(done), .wave_count(wave_count), .tail_idle(tail_idle)
   );

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 0;

   // reference model state
   int m_occ [S];
   int m_last = S - 1;
   int m_n = 0, m_slots = 0, m_cap = 0, m_issued = 0, m_out = 0;
   bit m_run = 0, m_done = 0, m_held = 0;
   int m_hsm = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_launch(input int n, input int sl);
      @(negedge clk);
      launch_valid  = 1'b1;
      launch_blocks = BLK_W'(n);
      launch_slots  = SLOT_W'(sl);
      asg_ready     = 1'b0;
      cpl_valid     = '0;
      #1;
      chk(launch_ready == 1'b1, "R1 launch ready when idle", launch_ready, 1);
      @(posedge clk);
      m_n = n; m_slots = sl; m_cap = sl * S; m_issued = 0; m_held = 0;
      if (n == 0 || sl == 0) begin m_done = 1; m_run = 0; end
      else begin m_done = 0; m_run = 1; end
   endtask

   task automatic step(input bit rdy, input logic [S-1:0] cv);
      bit ev, room; int es, mn; int pre [S];
      @(negedge clk);
      launch_valid = 1'b0;
      asg_ready    = rdy;
      cpl_valid    = cv;
      #1;
      mn = 1 << 20; room = 0;
      for (int i = 0; i < S; i++)
         if (m_occ[i] < m_slots && m_occ[i] < mn) begin mn = m_occ[i]; room = 1; end
      es = -1;
      for (int k = 1; k <= S; k++) begin
         int idx;
         idx = (m_last + k) % S;
         if (es < 0 && m_occ[idx] < m_slots && m_occ[idx] == mn) es = idx;
      end
      if (m_held) es = m_hsm;
      ev = m_run && (m_issued < m_n) && (m_held || room);
      chk(asg_valid == ev, "R6 offer valid", asg_valid, ev);
      if (ev) begin
         chk(int'(asg_sm) == es, "R4 target SM", asg_sm, es);
         chk(int'(asg_block) == m_issued, "R2 block id", asg_block, m_issued);
      end
      for (int i = 0; i < S; i++)
         chk(cpl_ready[i] == (m_occ[i] > 0), "R5 completion ready", cpl_ready[i], m_occ[i] > 0);
      chk(done == m_done, "R7 done level", done, m_done);
      chk(launch_ready == !m_run, "R1 launch ready", launch_ready, !m_run);
      @(posedge clk);
      for (int i = 0; i < S; i++) pre[i] = m_occ[i];
      for (int i = 0; i < S; i++)
         if (cv[i] && pre[i] > 0) begin m_occ[i]--; m_out--; end
      if (ev && rdy) begin
         m_occ[es]++; m_out++; m_issued++; m_last = es; m_held = 0;
      end else begin
         m_held = ev; m_hsm = es;
      end
      if (m_run && m_issued == m_n && m_out == 0) begin m_done = 1; m_run = 0; end
   endtask

   task automatic chk_waves(input string tag);
      int ew, rem, ei;
      #1;
      ew = (m_cap == 0 || m_issued == 0) ? 0 : (m_issued + m_cap - 1) / m_cap;
      if (ew == 0) ei = S;
      else begin
         rem = m_issued - (ew - 1) * m_cap;
         ei = S - ((rem < S) ? rem : S);
      end
      chk(int'(wave_count) == ew, {tag, " R9 wave count"}, wave_count, ew);
      chk(int'(tail_idle) == ei, {tag, " R10 tail idle"}, tail_idle, ei);
   endtask

   task automatic drain(input logic [S-1:0] cv, input int limit);
      for (int c = 0; c < limit && !m_done; c++) step(1'b1, cv);
   endtask

   task automatic t_reset();
      @(negedge clk); #1;
      chk(launch_ready == 1'b1, "R1 reset launch ready", launch_ready, 1);
      chk(asg_valid == 1'b0, "R1 reset no offer", asg_valid, 0);
      chk(done == 1'b0, "R1 reset done low", done, 0);
      chk(cpl_ready == '0, "R5 reset no completion ready", cpl_ready, 0);
      chk(wave_count == '0, "R9 reset waves", wave_count, 0);
      chk(int'(tail_idle) == S, "R10 reset tail idle", tail_idle, S);
   endtask

   task automatic t_few_blocks();
      do_launch(5, 2);
      for (int c = 0; c < 6; c++) step(1'b1, '0);
      chk(m_issued == 5 && asg_valid == 1'b0, "R4 only five SMs fed", asg_valid, 0);
      chk_waves("few");
      step(1'b0, '1);
      step(1'b0, '0);
      chk(done == 1'b1, "R7 done after last completion", done, 1);
   endtask

   task automatic t_zero();
      do_launch(0, 3);
      step(1'b1, '0);
      chk(done == 1'b1 && asg_valid == 1'b0, "R8 zero blocks done", done, 1);
      chk_waves("zero blocks R8");
      do_launch(7, 0);
      step(1'b1, '0);
      step(1'b1, '0);
      chk(done == 1'b1 && asg_valid == 1'b0, "R8 zero slots done", done, 1);
      chk_waves("zero slots R8");
   endtask

   task automatic t_stall();
      do_launch(20, 2);
      for (int c = 0; c < 18; c++) step(1'b1, '0);
      chk(asg_valid == 1'b0, "R6 stalled when full", asg_valid, 0);
      chk(m_out == 16, "R3 capacity filled", m_out, 16);
      step(1'b1, S'(1) << 2);
      step(1'b0, S'(1) << 5);
      step(1'b0, S'(1) << 6);
      step(1'b1, S'(1) << 2);   // assign and retire on same SM
      step(1'b1, '0);
      chk(cpl_ready[2] == 1'b1, "R5 same-cycle net zero", cpl_ready[2], 1);
      drain('1, 200);
      chk(m_done == 1'b1, "R7 stall grid completes", m_done, 1);
      chk_waves("stall");
   endtask

   task automatic t_many();
      do_launch(100, 3);
      for (int c = 0; c < 3000 && !m_done; c++)
         step((c % 3) != 0, (S'(1) << (c % S)) | (S'(1) << ((c * 3 + 1) % S)));
      chk(m_done == 1'b1, "R7 long grid completes", m_done, 1);
      chk(m_issued == 100, "R2 all ids handed out", m_issued, 100);
      chk_waves("many");
   endtask

   initial begin
      for (int i = 0; i < S; i++) m_occ[i] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_few_blocks();
      t_zero();
      t_stall();
      t_many();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_checks++;
         n_fails++;
         $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

endmodule